// File: doc/BRIEF.md
# Synchronous SRAM Read Output Pipeline Controller

This block sits between the memory array and the data pins of a synchronous SRAM. Each cycle it takes the array read data and the registered command for that cycle, which is read, deselect or neither. It produces the value for the data pins and a tri-state drive enable. Two static mode inputs shape the timing.

The first mode input picks the read latency. In registered (pipeline) mode the read data passes through a rising-edge output register and appears one cycle after the read is accessed. This gives 3-1-1-1 burst timing at the pins. In flow-through mode the register is bypassed and the data appears in the access cycle, which gives 2-1-1-1 timing.

The second mode input picks how fast the bus is released after a deselect. With single-cycle deselect the drivers drop in the cycle the deselect is captured. With dual-cycle deselect in pipeline mode, the drivers stay on for one more full cycle and drop after the following rising edge. The output enable gates the drivers combinationally, with no clock involved. Board pull resistors put the pins in the pipeline, single-cycle-deselect state: `pipeSel` high and `dualSel` low.

Top module: `read_out_pipe`

## Requirements
- R1: After reset, and before any read, `driveEn` is 0 and `dataOut` is all zeros.
- R2: With `pipeSel`=1, a read in cycle t with array data D gives `dataOut`=D and `driveEn`=1 (with `outEnable`=1) in cycle t+1.
- R3: With `pipeSel`=0, a read in cycle t drives `dataOut` equal to `arrayData` of cycle t and `driveEn`=1 in cycle t itself.
- R4: In a cycle with neither read nor deselect, `dataOut` shows the data of the last accepted read, and the drive state stays what it was.
- R5: With `pipeSel`=1 and `dualSel`=1, a deselect in cycle t leaves the drive state of cycle t unchanged and makes `driveEn` 0 from cycle t+1.
- R6: With `pipeSel`=1 and `dualSel`=0, a deselect in cycle t makes `driveEn` 0 in cycle t.
- R7: With `pipeSel`=0, a deselect in cycle t makes `driveEn` 0 in cycle t, whatever `dualSel` is.
- R8: `outEnable`=0 forces `driveEn` to 0 in the same cycle, without changing the stored data or drive state.
- R9: A read following a deselect turns the drivers back on in the same cycle the new read data first appears, so data left over from before the deselect is never driven.
- R10: When read and deselect are both asserted in one cycle, the deselect wins. The read data is not captured and `dataOut` keeps its previous value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous reset, active low |
| pipeSel | input | 1 | 1 = registered output, 0 = flow-through |
| dualSel | input | 1 | 1 = dual-cycle deselect, 0 = single-cycle |
| cmdRead | input | 1 | Registered read command for this cycle |
| cmdDesel | input | 1 | Registered deselect command for this cycle |
| arrayData | input | DATA_W | Array read data for this cycle's access |
| outEnable | input | 1 | Asynchronous output enable, active high |
| dataOut | output | DATA_W | Data presented to the pin drivers |
| driveEn | output | 1 | Tri-state drive enable for the data pins |

## Verification
The assertions assume that `cmdRead` and `cmdDesel` are clean registered levels that change only after a clock edge. They also assume `arrayData` is stable for the whole cycle in which a read captures it. The bench drives every input one nanosecond after the rising edge and samples outputs at the falling edge, so all inputs are settled at both edges. Mode inputs are changed only between sequences. The design treats them as static, and no assertion depends on their history.

// File: rtl/rop_pkg.sv
package rop_pkg;
  typedef struct packed {
    logic loadData;  // capture array data into the output register
    logic bypass;    // route array data straight to the pins this cycle
  } ropStrobes_t;
endpackage

// File: rtl/rop_ctrl.sv
module rop_ctrl
  import rop_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        pipeSel,
  input  logic        dualSel,
  input  logic        cmdRead,
  input  logic        cmdDesel,
  output ropStrobes_t stb,
  output logic        driveValid
);
  logic driveState;   // drive state as seen one stage after the command
  logic acceptRead;

  assign acceptRead   = cmdRead && !cmdDesel;
  assign stb.loadData = acceptRead;
  assign stb.bypass   = !pipeSel && acceptRead;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)           driveState <= 1'b0;
    else if (cmdDesel)   driveState <= 1'b0;
    else if (acceptRead) driveState <= 1'b1;
  end

  always_comb begin
    if (pipeSel) begin
      if (dualSel) driveValid = driveState;
      else         driveValid = cmdDesel ? 1'b0 : driveState;
    end else begin
      if (cmdDesel)        driveValid = 1'b0;
      else if (acceptRead) driveValid = 1'b1;
      else                 driveValid = driveState;
    end
  end

  assert_desel_clears_R5: assert property (@(posedge clk) disable iff (!rstN)
    cmdDesel |=> !driveState);
  assert_read_sets_R9: assert property (@(posedge clk) disable iff (!rstN)
    (cmdRead && !cmdDesel) |=> driveState);
  assert_idle_holds_R4: assert property (@(posedge clk) disable iff (!rstN)
    (!cmdRead && !cmdDesel) |=> $stable(driveState));
  assert_desel_priority_R10: assert property (@(posedge clk) disable iff (!rstN)
    (cmdRead && cmdDesel) |-> !stb.loadData);
endmodule

// File: rtl/rop_datapath.sv
module rop_datapath
  import rop_pkg::*;
#(
  parameter int DATA_W = 72
) (
  input  logic              clk,
  input  logic              rstN,
  input  ropStrobes_t       stb,
  input  logic [DATA_W-1:0] arrayData,
  output logic [DATA_W-1:0] dataOut
);
  logic [DATA_W-1:0] outReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)             outReg <= '0;
    else if (stb.loadData) outReg <= arrayData;
  end

  assign dataOut = stb.bypass ? arrayData : outReg;

  assert_capture_R2: assert property (@(posedge clk) disable iff (!rstN)
    stb.loadData |=> (outReg == $past(arrayData)));
  assert_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    !stb.loadData |=> $stable(outReg));
endmodule

// File: rtl/read_out_pipe.sv
module read_out_pipe
  import rop_pkg::*;
#(
  parameter int DATA_W = 72
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              pipeSel,
  input  logic              dualSel,
  input  logic              cmdRead,
  input  logic              cmdDesel,
  input  logic [DATA_W-1:0] arrayData,
  input  logic              outEnable,
  output logic [DATA_W-1:0] dataOut,
  output logic              driveEn
);
  ropStrobes_t stb;
  logic        driveValid;

  rop_ctrl i_ctrl (
    .clk(clk), .rstN(rstN), .pipeSel(pipeSel), .dualSel(dualSel),
    .cmdRead(cmdRead), .cmdDesel(cmdDesel), .stb(stb), .driveValid(driveValid)
  );

  rop_datapath #(.DATA_W(DATA_W)) i_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .arrayData(arrayData), .dataOut(dataOut)
  );

  assign driveEn = driveValid && outEnable;

  always_comb begin
    if (rstN && !outEnable) assert_oe_gate_R8: assert (!driveEn);
    if (rstN && cmdDesel && !(pipeSel && dualSel))
      assert_fast_release_R6: assert (!driveEn);
  end
endmodule

// File: tb/test_read_out_pipe.sv
module test_read_out_pipe;
  localparam int W = 72;

  logic clk = 1'b0, rstN = 1'b0;
  logic pipeSel = 1'b1, dualSel = 1'b0, cmdRead = 1'b0, cmdDesel = 1'b0;
  logic outEnable = 1'b1;
  logic [W-1:0] arrayData = '0;
  logic [W-1:0] dataOut;
  logic driveEn;

  read_out_pipe #(.DATA_W(W)) i_read_out_pipe (
    .clk(clk), .rstN(rstN), .pipeSel(pipeSel), .dualSel(dualSel),
    .cmdRead(cmdRead), .cmdDesel(cmdDesel), .arrayData(arrayData),
    .outEnable(outEnable), .dataOut(dataOut), .driveEn(driveEn)
  );

  always #10 clk = ~clk;  // 50 MHz

  typedef struct {
    logic [W-1:0] data;
    logic         en;
    string        tag;
  } expItem_t;

  expItem_t q[$];
  int compared = 0, mismatched = 0;
  bit finished = 0;
  logic         mDrv = 1'b0;
  logic [W-1:0] mData = '0;

  // one command cycle; expected pins computed from the requirements
  task automatic step(input logic rd, input logic ds, input logic [W-1:0] arr,
                      input logic oe, input string tag);
    expItem_t it;
    logic valid;
    @(posedge clk); #1;
    cmdRead = rd; cmdDesel = ds; arrayData = arr; outEnable = oe;
    if (pipeSel) valid = dualSel ? mDrv : (ds ? 1'b0 : mDrv);
    else         valid = ds ? 1'b0 : (rd ? 1'b1 : mDrv);
    it.data = (!pipeSel && rd && !ds) ? arr : mData;
    it.en   = valid && oe;
    it.tag  = tag;
    q.push_back(it);
    if (ds) mDrv = 1'b0;
    else if (rd) begin mDrv = 1'b1; mData = arr; end
  endtask

  always @(negedge clk) begin
    if (q.size() > 0) begin
      expItem_t it;
      it = q.pop_front();
      compared++;
      if (dataOut !== it.data || driveEn !== it.en) begin
        mismatched++;
        $display("FAIL %s: data=%h en=%b expected data=%h en=%b",
                 it.tag, dataOut, driveEn, it.data, it.en);
      end
    end
  end

  function automatic logic [W-1:0] pat(input int n);
    return {8'(n), 32'hA5A50000 + 32'(n), 32'h0F0F0000 ^ 32'(n * 7)};
  endfunction

  initial begin
    repeat (3) @(posedge clk);
    #1;
    compared++;  // R1 during reset
    if (driveEn !== 1'b0 || dataOut !== '0) begin
      mismatched++;
      $display("FAIL R1: data=%h en=%b expected data=0 en=0", dataOut, driveEn);
    end
    rstN = 1'b1;
    step(0, 0, pat(99), 1, "R1");
    // pipeline, dual-cycle deselect
    pipeSel = 1; dualSel = 1;
    step(1, 0, pat(1), 1, "R2");
    step(1, 0, pat(2), 1, "R2");
    step(0, 0, pat(50), 1, "R2");
    step(0, 0, pat(51), 1, "R4");
    step(0, 1, pat(52), 1, "R5");
    step(0, 0, pat(53), 1, "R5");
    step(1, 0, pat(3), 1, "R9");
    step(1, 1, pat(4), 1, "R9");
    step(0, 0, pat(54), 1, "R10");
    step(0, 0, pat(55), 1, "R10");
    // pipeline, single-cycle deselect
    dualSel = 0;
    step(1, 0, pat(5), 1, "R2");
    step(0, 1, pat(56), 1, "R6");
    step(1, 0, pat(6), 1, "R9");
    step(1, 0, pat(7), 0, "R8");
    step(0, 0, pat(57), 0, "R8");
    step(0, 0, pat(58), 1, "R8");
    // flow-through
    pipeSel = 0;
    step(1, 0, pat(8), 1, "R3");
    step(0, 0, pat(59), 1, "R4");
    step(0, 1, pat(60), 1, "R7");
    dualSel = 1;
    step(1, 0, pat(9), 1, "R3");
    step(0, 1, pat(61), 1, "R7");
    step(0, 0, pat(62), 1, "R4");
    step(1, 1, pat(10), 1, "R10");
    step(0, 0, pat(63), 1, "R10");
    repeat (3) @(posedge clk);
    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #200000;
    if (!finished) begin
      mismatched++;
      $display("FAIL watchdog: run did not end, expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule